// File: doc/BRIEF.md
# Nine-Bit Word Byte Packer

This block prepares traffic for a display controller that expects 9-bit serial words, where the leading bit tells command (0) from data (1). The link it feeds can only move whole bytes, so the packer concatenates the 9-bit words most significant bit first. Each group of eight words fills exactly nine bytes. Upstream logic offers one item per valid/ready handshake: a byte or a 16-bit pixel, a command/data flag, and an end-of-run marker. Downstream logic takes the packed bytes through a second valid/ready handshake. The final byte of a run carries an end flag.

Every command travels alone in its own block. Seven all-zero words, which the display reads as no-operation commands, come before the command word. A data run fills blocks eight words at a time. A run that stops short of a full block is completed with zero bits. When a 16-bit pixel is given, its two halves become two consecutive data words, high half first, and a pixel may straddle two blocks. While a block's bytes are draining, no new input is taken.

Top module: `nbp_packer`

## Requirements
- R1: After reset `out_valid` is 0, and `in_ready` is 1 while no input is offered.
- R2: A data item becomes the 9-bit word {1, byte}. Eight words are concatenated with word 0 in the most significant position, and the 72-bit block leaves as 9 bytes, highest bits first. Eight zero data bytes therefore give 80 40 20 10 08 04 02 01 00 (hex).
- R3: A command item (`in_dc`=0) produces a block of its own: eight bytes of 00 followed by the command code as the ninth byte.
- R4: A data item with `in_last` set closes a partly filled block. The unused word slots are sent as zero bits.
- R5: A data item with `in_wide`=1 gives two consecutive data words: `in_data[15:8]` first, then `in_data[7:0]`. When only one slot is left, the second word opens the next block.
- R6: When a command arrives while a data block is partly filled and has no end marker, the partial block is sent first, zero padded and with no end flag. The command block follows it.
- R7: `in_wide` has no effect on a command: only `in_data[7:0]` is sent as the command code. A non-wide data item also uses only `in_data[7:0]`.
- R8: `in_ready` is 0 whenever `out_valid` is 1. While `out_valid` is 1 and `out_ready` is 0, `out_byte` and `out_last` hold their values.
- R9: `out_last` is 1 only on the final byte of a block that was closed by an item carrying `in_last`. After that byte is taken, `out_valid` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input item offered |
| in_ready | output | 1 | Input item accepted when high together with in_valid |
| in_data | input | 16 | Item value; bits 7:0 unless a wide data item |
| in_dc | input | 1 | 0 = command, 1 = parameter/pixel data |
| in_wide | input | 1 | Data item is a 16-bit pixel |
| in_last | input | 1 | Item ends the current run |
| out_valid | output | 1 | Packed byte available |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | 8 | Packed byte |
| out_last | output | 1 | Final byte of a run |

## Verification
The bench uses the default block of eight words, which makes nine-byte blocks. With that size, short blocks, full blocks, and a pixel split across a block boundary can all be reached with streams of a few dozen items. The bench runs each scenario with a downstream that is always ready, then repeats key streams with a toggling ready and with a ready held low. The held-low case shows that input stalls while a block drains and that the output holds still. Fixed byte patterns pin the bit placement. A model built from the requirements supplies the expected bytes for mixed streams of commands and data.

// File: rtl/nbp_pkg.sv
package nbp_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = BYTE_W + 1;
    localparam int PIX_W  = 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] b;
        logic              dc;
        logic              last;
    } item_t;
endpackage

// File: rtl/nbp_split.sv
module nbp_split
    import nbp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_data,
    input  logic             in_dc,
    input  logic             in_wide,
    input  logic             in_last,
    output logic             it_valid,
    input  logic             it_ready,
    output item_t            it
);
    typedef struct packed {
        logic              pend;
        logic [BYTE_W-1:0] lo;
        logic              last;
    } split_st_t;

    split_st_t st_d, st_q;
    logic      split;

    always_comb begin
        st_d    = st_q;
        split   = in_wide && in_dc;
        it      = '0;
        if (st_q.pend) begin
            it_valid = 1'b1;
            it.b     = st_q.lo;
            it.dc    = 1'b1;
            it.last  = st_q.last;
            in_ready = 1'b0;
            if (it_ready) begin
                st_d.pend = 1'b0;
            end
        end else begin
            it_valid = in_valid;
            it.b     = split ? in_data[PIX_W-1:BYTE_W] : in_data[BYTE_W-1:0];
            it.dc    = in_dc;
            it.last  = in_last && !split;
            in_ready = it_ready;
            if (in_valid && it_ready && split) begin
                st_d.pend = 1'b1;
                st_d.lo   = in_data[BYTE_W-1:0];
                st_d.last = in_last;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/nbp_assemble.sv
module nbp_assemble
    import nbp_pkg::*;
#(
    parameter int BLK_WORDS = 8,
    localparam int BLK_BITS = BLK_WORDS * WORD_W,
    localparam int CNT_W    = $clog2(BLK_WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                it_valid,
    output logic                it_ready,
    input  item_t               it,
    input  logic                ser_idle,
    output logic                ld,
    output logic [BLK_BITS-1:0] ld_blk,
    output logic                ld_last
);
    typedef struct packed {
        logic [BLK_BITS-1:0] acc;
        logic [CNT_W-1:0]    cnt;
    } asm_st_t;

    asm_st_t             st_d, st_q;
    logic                flush_first;
    logic                full;
    int                  sh_amt;
    logic [BLK_BITS-1:0] word_ext;
    logic [BLK_BITS-1:0] merged;

    always_comb begin
        st_d        = st_q;
        ld          = 1'b0;
        ld_blk      = st_q.acc;
        ld_last     = 1'b0;
        flush_first = it_valid && !it.dc && (st_q.cnt != '0);
        it_ready    = ser_idle && !flush_first;
        full        = (st_q.cnt == CNT_W'(BLK_WORDS - 1));
        sh_amt      = BLK_BITS - WORD_W * (int'(st_q.cnt) + 1);
        word_ext    = BLK_BITS'({1'b1, it.b});
        merged      = st_q.acc | (word_ext << sh_amt);

        if (ser_idle && flush_first) begin
            ld       = 1'b1;
            ld_blk   = st_q.acc;
            st_d.acc = '0;
            st_d.cnt = '0;
        end else if (it_valid && it_ready) begin
            if (!it.dc) begin
                ld      = 1'b1;
                ld_blk  = BLK_BITS'({1'b0, it.b});
                ld_last = it.last;
            end else if (full || it.last) begin
                ld       = 1'b1;
                ld_blk   = merged;
                ld_last  = it.last;
                st_d.acc = '0;
                st_d.cnt = '0;
            end else begin
                st_d.acc = merged;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/nbp_serial.sv
module nbp_serial
    import nbp_pkg::*;
#(
    parameter int BLK_BITS = 72,
    localparam int BLK_BYTES = BLK_BITS / BYTE_W,
    localparam int IDX_W     = $clog2(BLK_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld,
    input  logic [BLK_BITS-1:0] ld_blk,
    input  logic                ld_last,
    output logic                idle,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [BYTE_W-1:0]   out_byte,
    output logic                out_last
);
    typedef struct packed {
        logic [BLK_BITS-1:0] sh;
        logic [IDX_W-1:0]    idx;
        logic                busy;
        logic                last;
    } ser_st_t;

    ser_st_t st_d, st_q;
    logic    at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.idx == IDX_W'(BLK_BYTES - 1));
        if (ld) begin
            st_d.sh   = ld_blk;
            st_d.idx  = '0;
            st_d.busy = 1'b1;
            st_d.last = ld_last;
        end else if (st_q.busy && out_ready) begin
            if (at_end) begin
                st_d.busy = 1'b0;
                st_d.last = 1'b0;
            end else begin
                st_d.sh  = st_q.sh << BYTE_W;
                st_d.idx = st_q.idx + 1'b1;
            end
        end
        idle      = !st_q.busy;
        out_valid = st_q.busy;
        out_byte  = st_q.sh[BLK_BITS-1 -: BYTE_W];
        out_last  = st_q.busy && st_q.last && at_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/nbp_packer.sv
module nbp_packer
    import nbp_pkg::*;
#(
    parameter int BLK_WORDS = 8,
    localparam int BLK_BITS = BLK_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_data,
    input  logic              in_dc,
    input  logic              in_wide,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_last
);
    logic                it_valid;
    logic                it_ready;
    item_t               it;
    logic                ser_idle;
    logic                ld;
    logic [BLK_BITS-1:0] ld_blk;
    logic                ld_last;

    nbp_split u_split (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .in_dc    (in_dc),
        .in_wide  (in_wide),
        .in_last  (in_last),
        .it_valid (it_valid),
        .it_ready (it_ready),
        .it       (it)
    );

    nbp_assemble #(.BLK_WORDS(BLK_WORDS)) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .it_valid (it_valid),
        .it_ready (it_ready),
        .it       (it),
        .ser_idle (ser_idle),
        .ld       (ld),
        .ld_blk   (ld_blk),
        .ld_last  (ld_last)
    );

    nbp_serial #(.BLK_BITS(BLK_BITS)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (ld),
        .ld_blk    (ld_blk),
        .ld_last   (ld_last),
        .idle      (ser_idle),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_byte  (out_byte),
        .out_last  (out_last)
    );
endmodule

// File: rtl/nbp_checker.sv
module nbp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_byte,
    input logic       out_last
);
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid); // R1
    AST_NO_INPUT_WHILE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R8
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last))); // R8
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid); // R9
    AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid); // R9
endmodule

bind nbp_packer nbp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .out_last  (out_last)
);

// File: tb/nbp_packer_test.sv
module nbp_packer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        in_dc = 1'b0;
    logic        in_wide = 1'b0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_byte;
    logic        out_last;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rmode  = 0;

    logic [7:0] exp_b[$];
    logic       exp_l[$];
    logic [7:0] got_b[$];
    logic       got_l[$];
    logic [8:0] mw[$];

    nbp_packer uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_dc(in_dc), .in_wide(in_wide), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .out_last(out_last)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            summary();
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rmode == 0)      out_ready = 1'b1;
        else if (rmode == 1) out_ready = cyc[0] ^ cyc[2];
        else                 out_ready = 1'b0;
    end

    always begin
        @(negedge clk);
        #4;
        if (rst_n && out_valid && out_ready) begin
            got_b.push_back(out_byte);
            got_l.push_back(out_last);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected-stream model written from the requirements
    task automatic emit_blk(input logic lastf);
        logic [71:0] blk;
        blk = '0;
        foreach (mw[k]) blk[71-9*k -: 9] = mw[k];
        for (int j = 0; j < 9; j++) begin
            exp_b.push_back(blk[71-8*j -: 8]);
            exp_l.push_back(lastf && (j == 8));
        end
        mw.delete();
    endtask

    task automatic model(input logic dc, input logic [7:0] b, input logic lastf);
        if (!dc) begin
            if (mw.size() != 0) emit_blk(1'b0);
            for (int k = 0; k < 7; k++) mw.push_back(9'h000);
            mw.push_back({1'b0, b});
            emit_blk(lastf);
        end else begin
            mw.push_back({1'b1, b});
            if (mw.size() == 8 || lastf) emit_blk(lastf);
        end
    endtask

    task automatic send(input logic [15:0] d, input logic dc, input logic wide, input logic lastf);
        if (dc && wide) begin
            model(1'b1, d[15:8], 1'b0);
            model(1'b1, d[7:0], lastf);
        end else begin
            model(dc, d[7:0], lastf);
        end
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_dc = dc; in_wide = wide; in_last = lastf;
        #4;
        while (!in_ready) begin
            @(negedge clk);
            #4;
        end
        @(negedge clk);
        in_valid = 1'b0; in_data = 16'hxxxx; in_wide = 1'b0; in_last = 1'b0;
    endtask

    task automatic finish_cmp(input string req);
        int n;
        n = 0;
        while (got_b.size() < exp_b.size() && n < 3000) begin
            @(negedge clk);
            n++;
        end
        repeat (12) @(negedge clk);
        chk(got_b.size() == exp_b.size(), {req, " count"}, got_b.size(), exp_b.size());
        for (int j = 0; j < exp_b.size() && j < got_b.size(); j++) begin
            chk(got_b[j] == exp_b[j], {req, " byte"}, got_b[j], exp_b[j]);
            chk(got_l[j] == exp_l[j], "R9 out_last", got_l[j], exp_l[j]);
        end
    endtask

    task automatic clear_q();
        exp_b.delete(); exp_l.delete(); got_b.delete(); got_l.delete(); mw.delete();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #4;
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    endtask

    task automatic t_zero_data();
        clear_q();
        for (int i = 0; i < 8; i++) send(16'h0000, 1'b1, 1'b0, i == 7);
        finish_cmp("R2 zeros");
        for (int j = 0; j < 9 && j < got_b.size(); j++)
            chk(got_b[j] == ((j < 8) ? (8'h80 >> j) : 8'h00), "R2 literal", got_b[j], (j < 8) ? (8'h80 >> j) : 0);
    endtask

    task automatic t_command();
        clear_q();
        send(16'h002C, 1'b0, 1'b0, 1'b1);
        finish_cmp("R3 command");
        for (int j = 0; j < 9 && j < got_b.size(); j++)
            chk(got_b[j] == ((j == 8) ? 8'h2C : 8'h00), "R3 literal", got_b[j], (j == 8) ? 8'h2C : 0);
    endtask

    task automatic t_mixed_data();
        clear_q();
        send(16'h002A, 1'b0, 1'b0, 1'b0);
        send(16'h0012, 1'b1, 1'b0, 1'b0);
        send(16'h00F3, 1'b1, 1'b0, 1'b0);
        send(16'h00A5, 1'b1, 1'b0, 1'b0);
        send(16'h005C, 1'b1, 1'b0, 1'b0);
        send(16'h0001, 1'b1, 1'b0, 1'b0);
        send(16'h0080, 1'b1, 1'b0, 1'b0);
        send(16'h00FF, 1'b1, 1'b0, 1'b0);
        send(16'h0037, 1'b1, 1'b0, 1'b0);
        send(16'h00C4, 1'b1, 1'b0, 1'b1);
        finish_cmp("R2 mixed");
    endtask

    task automatic t_short();
        clear_q();
        send(16'h00B1, 1'b1, 1'b0, 1'b0);
        send(16'h0077, 1'b1, 1'b0, 1'b0);
        send(16'h00E9, 1'b1, 1'b0, 1'b1);
        finish_cmp("R4 short");
        if (got_b.size() == 9)
            chk(got_b[4] == 8'h00, "R4 pad", got_b[4], 0);
    endtask

    task automatic t_wide();
        clear_q();
        send(16'h002C, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 7; i++) send(16'h0010 + 16'(i), 1'b1, 1'b0, 1'b0);
        send(16'hABCD, 1'b1, 1'b1, 1'b0);
        send(16'h1234, 1'b1, 1'b1, 1'b1);
        finish_cmp("R5 wide");
    endtask

    task automatic t_flush();
        clear_q();
        send(16'h0055, 1'b1, 1'b0, 1'b0);
        send(16'h00AA, 1'b1, 1'b0, 1'b0);
        send(16'h0029, 1'b0, 1'b0, 1'b1);
        finish_cmp("R6 flush");
        if (got_l.size() > 8)
            chk(got_l[8] == 1'b0, "R6 no end flag", got_l[8], 0);
    endtask

    task automatic t_cmd_wide();
        clear_q();
        send(16'h1234, 1'b0, 1'b1, 1'b1);
        send(16'hFF0F, 1'b1, 1'b0, 1'b1);
        finish_cmp("R7 ignore");
        if (got_b.size() > 8)
            chk(got_b[8] == 8'h34, "R7 cmd code", got_b[8], 8'h34);
    endtask

    task automatic t_stall();
        logic [7:0] held;
        clear_q();
        rmode = 2;
        send(16'h005A, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        in_valid = 1'b1; in_dc = 1'b1; in_data = 16'h0077;
        #4;
        chk(out_valid == 1'b1, "R8 valid", out_valid, 1);
        chk(in_ready == 1'b0, "R8 in_ready", in_ready, 0);
        held = out_byte;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        #4;
        chk(out_byte == held && out_valid, "R8 hold", out_byte, held);
        rmode = 1;
        finish_cmp("R8 toggled");
        clear_q();
        for (int i = 0; i < 11; i++) send(16'(i * 37), 1'b1, i == 4, i == 10);
        finish_cmp("R8 toggled data");
        rmode = 0;
    endtask

    initial begin
        t_reset();
        t_zero_data();
        t_command();
        t_mixed_data();
        t_short();
        t_wide();
        t_flush();
        t_cmd_wide();
        t_stall();
        summary();
        $finish;
    end
endmodule